// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer Bank

This block is a bank of identical up-counting timer channels behind a simple word-addressed read/write port. Each channel has four registers: control (enable, counter clear, operating mode), clock setup (source select and divider), a read-only counter and a compare value. Two registers shared by the bank hold one bit per channel: an interrupt mask and a pending/acknowledge register. Channel n (counting from 1) owns bit n-1 in both.

A channel counts effective ticks. An effective tick is a pulse on the selected tick-enable input (fast system tick or slow 32 kHz tick), optionally halved by the divider. On a counting tick where the incremented value equals the compare value, the channel flags a match. The operating mode then decides what happens next: a one-shot channel stops, a repeat channel reloads to zero, and a free-running channel keeps counting and wraps at the counter's maximum. Software enables interrupts per channel and clears pending flags by writing ones.

Reads are combinational from the address. Writes take effect at the clock edge on which `wr_en_i` is high. Address bits [1:0] are ignored. Bits [ADDR_W-1:4] give the page: page 0 holds the shared registers, and page n holds channel n. Bits [3:2] select the slot within a page.

Top module: `gpt_bank`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and all `irq_ch_o` bits are low.
- R2: Register map. The mask is at 0x00 and pending/acknowledge is at 0x08. Channel n has control at 0x10*n, clock setup at 0x04+0x10*n, counter at 0x08+0x10*n and compare at 0x0C+0x10*n. Other addresses read zero. Control reads back enable in bit 0 and mode in bits [5:4]. The clear bit (bit 1) always reads 0. Clock setup reads back source in bit 4 and divider in bits [3:0].
- R3: An enabled channel adds one per effective tick. A disabled channel holds its count. Writes to the counter address are ignored.
- R4: Clock-setup bit 4 = 0 counts `tick_fast_i` and bit 4 = 1 counts `tick_slow_i`.
- R5: Divider field value 1 counts every second source tick, and any other value counts every tick. After a clock-setup write or a counter clear, the first counted tick is the second source tick.
- R6: A control write with bit 1 set zeroes the counter on that edge, overriding any tick.
- R7: A counting tick whose incremented count equals the compare value sets the channel's pending bit.
- R8: Mode 0 (one-shot): on a match the count stays at the compare value and the enable bit clears, unless a control write occurs on the same edge.
- R9: Mode 1 (repeat): on a match the counter becomes zero and the channel keeps counting.
- R10: Modes 3 and 2 (free-running): a match does not alter the count, and the counter wraps from its maximum to zero.
- R11: Writing pending/acknowledge clears each pending bit written as 1 and leaves bits written as 0 alone. A match on the same edge wins over the clear.
- R12: `irq_ch_o[n-1]` is pending bit n-1 AND mask bit n-1. `irq_o` is the OR of all `irq_ch_o` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_fast_i | input | 1 | Fast system tick enable |
| tick_slow_i | input | 1 | Slow 32 kHz tick enable |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_ch_o | output | N_CH | Per-channel interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
The counter is driven with dense fast ticks, sparse slow ticks and alternating tick patterns. Dense ticks expose off-by-one errors in the match point. Sparse and alternating patterns reveal whether the source select and the halving phase pick the correct pulses. Each mode is run against small compare values, which separates stopping, reloading and continuing after a match. A long run through the counter maximum confirms the free-running wrap. Acknowledge writes are issued on the same edge as a match, and with zero bits, to show the set-over-clear priority. A long stretch of mixed random writes and ticks is compared cycle by cycle against a behavioural model, catching interactions between writes and counting on a shared edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_REPEAT  = 2'd1,
    MODE_RSVD    = 2'd2,
    MODE_FREE    = 2'd3
  } gpt_mode_e;

  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_CLK  = 2'd1;
  localparam logic [1:0] SLOT_CNT  = 2'd2;
  localparam logic [1:0] SLOT_CMP  = 2'd3;

  localparam logic [1:0] SLOT_MASK = 2'd0;
  localparam logic [1:0] SLOT_PEND = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_SRC_BIT   = 4;
  localparam int DIV_W         = 4;
endpackage

// File: rtl/gpt_decode.sv
module gpt_decode
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_CH   = 4,
  localparam int IDX_W = ADDR_W - 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  page_o,
  output logic [1:0]        slot_o,
  output logic              wr_mask_o,
  output logic              wr_ack_o,
  output logic [N_CH-1:0]   wr_ctrl_o,
  output logic [N_CH-1:0]   wr_clk_o,
  output logic [N_CH-1:0]   wr_cmp_o
);
  assign page_o    = addr_i[ADDR_W-1:4];
  assign slot_o    = addr_i[3:2];
  assign wr_mask_o = wr_en_i && (page_o == '0) && (slot_o == SLOT_MASK);
  assign wr_ack_o  = wr_en_i && (page_o == '0) && (slot_o == SLOT_PEND);

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    logic page_hit;
    assign page_hit     = wr_en_i && (page_o == IDX_W'(c + 1));
    assign wr_ctrl_o[c] = page_hit && (slot_o == SLOT_CTRL);
    assign wr_clk_o[c]  = page_hit && (slot_o == SLOT_CLK);
    assign wr_cmp_o[c]  = page_hit && (slot_o == SLOT_CMP);
  end
endmodule

// File: rtl/gpt_prescale.sv
module gpt_prescale
  import gpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_fast_i,
  input  logic             tick_slow_i,
  input  logic             restart_i,
  output logic             step_o
);
  logic phase_q, phase_d;
  logic src_tick, halve;

  assign src_tick = src_sel_i ? tick_slow_i : tick_fast_i;
  assign halve    = (div_i == DIV_W'(1));
  assign step_o   = run_i && src_tick && (!halve || phase_q);

  always_comb begin
    phase_d = phase_q;
    if (restart_i)                      phase_d = 1'b0;
    else if (run_i && src_tick && halve) phase_d = !phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_clk_i,
  input  logic              wr_cmp_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              en_o,
  output logic [1:0]        mode_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] clk_rd_o,
  output logic [DATA_W-1:0] cnt_rd_o,
  output logic [DATA_W-1:0] cmp_rd_o
);
  logic             en_q, en_d;
  logic [1:0]       mode_q, mode_d;
  logic             src_q, src_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d, cnt_inc;
  logic             step, clr_req;

  assign clr_req = wr_ctrl_i && wdata_i[CTRL_CLR_BIT];

  gpt_prescale u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (en_q),
    .src_sel_i  (src_q),
    .div_i      (div_q),
    .tick_fast_i(tick_fast_i),
    .tick_slow_i(tick_slow_i),
    .restart_i  (wr_clk_i || clr_req),
    .step_o     (step)
  );

  assign cnt_inc = cnt_q + 1'b1;
  assign hit_o   = step && (cnt_inc == cmp_q);

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    src_d  = src_q;
    div_d  = div_q;
    cmp_d  = cmp_q;
    cnt_d  = cnt_q;
    if (step) begin
      if (hit_o && (mode_q == MODE_REPEAT)) cnt_d = '0;
      else                                  cnt_d = cnt_inc;
    end
    if (hit_o && (mode_q == MODE_ONESHOT)) en_d = 1'b0;
    if (wr_ctrl_i) begin
      en_d   = wdata_i[CTRL_EN_BIT];
      mode_d = wdata_i[CTRL_MODE_LSB +: 2];
      if (clr_req) cnt_d = '0;
    end
    if (wr_clk_i) begin
      src_d = wdata_i[CLK_SRC_BIT];
      div_d = wdata_i[DIV_W-1:0];
    end
    if (wr_cmp_i) cmp_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 2'd0;
      src_q  <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      cmp_q  <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      src_q  <= src_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_EN_BIT] = en_q;
    ctrl_rd_o[CTRL_MODE_LSB +: 2] = mode_q;
    clk_rd_o = '0;
    clk_rd_o[CLK_SRC_BIT] = src_q;
    clk_rd_o[DIV_W-1:0] = div_q;
    cnt_rd_o = '0;
    cnt_rd_o[CNT_W-1:0] = cnt_q;
    cmp_rd_o = '0;
    cmp_rd_o[CNT_W-1:0] = cmp_q;
  end
endmodule

// File: rtl/gpt_bank.sv
module gpt_bank
  import gpt_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   irq_ch_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 4;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [IDX_W-1:0] page;
  logic [1:0]       slot;
  logic             wr_mask, wr_ack;
  logic [N_CH-1:0]  wr_ctrl, wr_clk, wr_cmp;

  gpt_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_dec (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .page_o   (page),
    .slot_o   (slot),
    .wr_mask_o(wr_mask),
    .wr_ack_o (wr_ack),
    .wr_ctrl_o(wr_ctrl),
    .wr_clk_o (wr_clk),
    .wr_cmp_o (wr_cmp)
  );

  logic [N_CH-1:0]             hit_vec, en_vec;
  logic [N_CH-1:0][1:0]        mode_vec;
  logic [N_CH-1:0][CNT_W-1:0]  cnt_vec;
  logic [N_CH-1:0][DATA_W-1:0] ctrl_rd, clk_rd, cnt_rd, cmp_rd;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    gpt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .tick_fast_i(tick_fast_i),
      .tick_slow_i(tick_slow_i),
      .wr_ctrl_i  (wr_ctrl[c]),
      .wr_clk_i   (wr_clk[c]),
      .wr_cmp_i   (wr_cmp[c]),
      .wdata_i    (wdata_i),
      .hit_o      (hit_vec[c]),
      .en_o       (en_vec[c]),
      .mode_o     (mode_vec[c]),
      .cnt_o      (cnt_vec[c]),
      .ctrl_rd_o  (ctrl_rd[c]),
      .clk_rd_o   (clk_rd[c]),
      .cnt_rd_o   (cnt_rd[c]),
      .cmp_rd_o   (cmp_rd[c])
    );
  end

  logic [N_CH-1:0] mask_q, mask_d, pend_q, pend_d, ack_bits;

  assign ack_bits = wr_ack ? wdata_i[N_CH-1:0] : '0;

  always_comb begin
    mask_d = wr_mask ? wdata_i[N_CH-1:0] : mask_q;
    pend_d = (pend_q & ~ack_bits) | hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign irq_ch_o = pend_q & mask_q;
  assign irq_o    = |irq_ch_o;

  always_comb begin
    rdata_o = '0;
    if (page == '0) begin
      if (slot == SLOT_MASK)      rdata_o[N_CH-1:0] = mask_q;
      else if (slot == SLOT_PEND) rdata_o[N_CH-1:0] = pend_q;
    end
    for (int c = 0; c < N_CH; c++) begin
      if (page == IDX_W'(c + 1)) begin
        case (slot)
          SLOT_CTRL: rdata_o = ctrl_rd[c];
          SLOT_CLK:  rdata_o = clk_rd[c];
          SLOT_CNT:  rdata_o = cnt_rd[c];
          default:   rdata_o = cmp_rd[c];
        endcase
      end
    end
  end
endmodule

// File: rtl/gpt_bank_chk.sv
module gpt_bank_chk #(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wdata,
  input logic                      irq,
  input logic [N_CH-1:0]           hit,
  input logic [N_CH-1:0]           pend,
  input logic [N_CH-1:0]           en,
  input logic [N_CH-1:0][1:0]      mode,
  input logic [N_CH-1:0][CNT_W-1:0] cnt
);
  logic ack_wr;
  assign ack_wr = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(2));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr[ADDR_W-1:4] == IDX_W'(i + 1)) && (addr[3:2] == 2'd0);

    assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> pend[i]);

    assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && wdata[i] && !hit[i]) |=> !pend[i]);

    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && (mode[i] == 2'd0) && !ctrl_wr) |=> !en[i]);

    assert_repeat_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && (mode[i] == 2'd1) && !ctrl_wr) |=> (cnt[i] == '0));

    assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !ctrl_wr) |=> $stable(cnt[i]));
  end

  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (hit == '0) && !wr_en) |=> !irq);
endmodule

bind gpt_bank gpt_bank_chk #(
  .N_CH(N_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n_int),
  .wr_en(wr_en_i),
  .addr (addr_i),
  .wdata(wdata_i),
  .irq  (irq_o),
  .hit  (hit_vec),
  .pend (pend_q),
  .en   (en_vec),
  .mode (mode_vec),
  .cnt  (cnt_vec)
);

// File: tb/tb_gpt_bank.sv
module tb_gpt_bank;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int MAXC = (1 << CW) - 1;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq_ch;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int m_en[NCH], m_mode[NCH], m_src[NCH], m_div[NCH], m_cnt[NCH], m_cmp[NCH], m_ph[NCH];
  int m_mask = 0, m_pend = 0;

  always #HALF clk = ~clk;

  gpt_bank #(.N_CH(NCH), .CNT_W(CW), .DATA_W(32), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .tick_fast_i(tick_fast), .tick_slow_i(tick_slow),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_ch_o(irq_ch), .irq_o(irq)
  );

  function automatic int model_read(int a);
    int pg = (a >> 4) & 15;
    int sl = (a >> 2) & 3;
    if (pg == 0) begin
      if (sl == 0) return m_mask;
      if (sl == 2) return m_pend;
      return 0;
    end
    if (pg <= NCH) begin
      int c = pg - 1;
      case (sl)
        0: return m_en[c] | (m_mode[c] << 4);
        1: return (m_src[c] << 4) | m_div[c];
        2: return m_cnt[c];
        default: return m_cmp[c];
      endcase
    end
    return 0;
  endfunction

  task automatic model_step(bit wr, int a, int wd, bit tf, bit ts);
    int pg = (a >> 4) & 15;
    int sl = (a >> 2) & 3;
    int hits = 0;
    for (int c = 0; c < NCH; c++) begin
      bit srct = (m_src[c] != 0) ? ts : tf;
      bit div2 = (m_div[c] == 1);
      bit stp  = (m_en[c] != 0) && srct && (!div2 || (m_ph[c] != 0));
      int inc  = (m_cnt[c] + 1) & MAXC;
      bit hit  = stp && (inc == m_cmp[c]);
      if ((m_en[c] != 0) && srct && div2) m_ph[c] = 1 - m_ph[c];
      if (stp) m_cnt[c] = (hit && m_mode[c] == 1) ? 0 : inc;
      if (hit && m_mode[c] == 0) m_en[c] = 0;
      if (hit) hits |= (1 << c);
      if (wr && pg == c + 1) begin
        if (sl == 0) begin
          m_en[c] = wd & 1;
          m_mode[c] = (wd >> 4) & 3;
          if (((wd >> 1) & 1) != 0) begin m_cnt[c] = 0; m_ph[c] = 0; end
        end else if (sl == 1) begin
          m_src[c] = (wd >> 4) & 1;
          m_div[c] = wd & 15;
          m_ph[c] = 0;
        end else if (sl == 3) begin
          m_cmp[c] = wd & MAXC;
        end
      end
    end
    if (wr && pg == 0 && sl == 2) m_pend = m_pend & ~(wd & ((1 << NCH) - 1));
    m_pend = m_pend | hits;
    if (wr && pg == 0 && sl == 0) m_mask = wd & ((1 << NCH) - 1);
  endtask

  task automatic cyc(bit wr, int a, int wd, bit tf, bit ts, string tag);
    int exp_rd, exp_ch;
    bit exp_irq;
    @(negedge clk);
    wr_en = wr; addr = a[7:0]; wdata = wd; tick_fast = tf; tick_slow = ts;
    @(posedge clk);
    model_step(wr, a, wd, tf, ts);
    #1;
    exp_rd  = model_read(a);
    exp_ch  = m_pend & m_mask;
    exp_irq = (exp_ch != 0);
    vectors++;
    if (rdata !== exp_rd[31:0] || irq_ch !== exp_ch[NCH-1:0] || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s addr=%h: rdata=%h exp %h, irq_ch=%b exp %b, irq=%b exp %b",
               tag, a[7:0], rdata, exp_rd, irq_ch, exp_ch[NCH-1:0], irq, exp_irq);
    end
  endtask

  task automatic idle(int a, int n, bit tf, bit ts, string tag);
    for (int k = 0; k < n; k++) cyc(0, a, 0, tf, ts, tag);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_mode[c] = 0; m_src[c] = 0; m_div[c] = 0;
      m_cnt[c] = 0; m_cmp[c] = 0; m_ph[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values on every mapped slot and outside the map
    for (int a = 0; a < 'h58; a += 4) cyc(0, a, 0, 0, 0, "R1 reset");

    // R2: readback of the map, clear bit reads 0, counter write ignored (R3)
    cyc(1, 'h1C, 'h1A5, 0, 0, "R2 cmp write");
    cyc(0, 'h1C, 0, 0, 0, "R2 cmp readback");
    cyc(1, 'h00, 'hF, 0, 0, "R2 mask write");
    cyc(0, 'h00, 0, 0, 0, "R2 mask readback");
    cyc(1, 'h24, 'h1F, 0, 0, "R2 clk write");
    cyc(0, 'h24, 0, 0, 0, "R2 clk readback");
    cyc(1, 'h30, 'h22, 0, 0, "R2 ctrl clear bit");
    cyc(0, 'h30, 0, 0, 0, "R2 ctrl readback");
    cyc(1, 'h14, 'h0, 0, 0, "R2 clk restore");
    cyc(1, 'h1C, 'h0, 0, 0, "R2 cmp restore");

    // R3 counting on fast ticks, counter write ignored
    cyc(1, 'h10, 'h31, 0, 0, "R3 enable");
    for (int k = 0; k < 20; k++) cyc(0, 'h18, 0, (k % 3) != 0, 0, "R3 count");
    cyc(1, 'h18, 'h55, 1, 0, "R3 cnt write ignored");
    cyc(0, 'h18, 0, 0, 0, "R3 cnt after write");
    cyc(1, 'h10, 'h30, 0, 0, "R3 disable");
    idle('h18, 5, 1, 1, "R3 hold");

    // R4 slow source
    cyc(1, 'h24, 'h10, 0, 0, "R4 slow src");
    cyc(1, 'h20, 'h33, 0, 0, "R4 enable");
    for (int k = 0; k < 16; k++) cyc(0, 'h28, 0, 1, (k % 4) == 0, "R4 slow count");

    // R5 divide by two, then other field values count every tick
    cyc(1, 'h34, 'h01, 0, 0, "R5 div2");
    cyc(1, 'h30, 'h33, 0, 0, "R5 enable");
    for (int k = 0; k < 12; k++) cyc(0, 'h38, 0, (k % 2) == 0 || k > 7, 0, "R5 half");
    cyc(1, 'h34, 'h02, 0, 0, "R5 div field 2");
    idle('h38, 6, 1, 0, "R5 full rate");

    // R6 clear wins over a simultaneous tick
    cyc(1, 'h30, 'h33, 1, 0, "R6 clear with tick");
    cyc(0, 'h38, 0, 0, 0, "R6 cnt zero");

    // R7/R8 one-shot on channel 4
    cyc(1, 'h4C, 5, 0, 0, "R8 cmp");
    cyc(1, 'h40, 'h03, 0, 0, "R8 start");
    idle('h48, 8, 1, 0, "R8 oneshot cnt");
    cyc(0, 'h40, 0, 0, 0, "R8 enable cleared");
    cyc(0, 'h08, 0, 0, 0, "R7 pending set");

    // R9 repeat on channel 1
    cyc(1, 'h1C, 3, 0, 0, "R9 cmp");
    cyc(1, 'h10, 'h13, 0, 0, "R9 start");
    idle('h18, 12, 1, 0, "R9 reload");

    // R10 free-running wrap (mode 3) and mode 2
    cyc(1, 'h24, 'h00, 0, 0, "R10 fast src");
    cyc(1, 'h2C, 2, 0, 0, "R10 cmp");
    cyc(1, 'h20, 'h33, 0, 0, "R10 start");
    idle('h28, 300, 1, 0, "R10 wrap");
    cyc(1, 'h30, 'h23, 0, 0, "R10 mode2");
    idle('h38, 270, 1, 0, "R10 mode2 wrap");

    // R11 acknowledge: zero bits, selective clear, set wins
    cyc(1, 'h10, 'h00, 0, 0, "R11 stop ch1");
    cyc(1, 'h20, 'h00, 0, 0, "R11 stop ch2");
    cyc(1, 'h30, 'h00, 0, 0, "R11 stop ch3");
    cyc(1, 'h08, 'h0, 0, 0, "R11 ack zero");
    cyc(1, 'h08, 'h8, 0, 0, "R11 ack ch4");
    cyc(1, 'h08, 'hF, 0, 0, "R11 ack all");
    cyc(1, 'h1C, 1, 0, 0, "R11 cmp1");
    cyc(1, 'h10, 'h13, 0, 0, "R11 repeat every tick");
    cyc(0, 'h08, 0, 1, 0, "R11 hit");
    cyc(1, 'h08, 'h1, 1, 0, "R11 ack with hit");
    cyc(1, 'h08, 'h1, 0, 0, "R11 ack no hit");

    // R12 mask gating
    cyc(0, 'h08, 0, 1, 0, "R12 pend");
    cyc(1, 'h00, 'h0, 0, 0, "R12 masked");
    cyc(1, 'h00, 'h1, 0, 0, "R12 unmasked");
    cyc(1, 'h10, 'h00, 0, 0, "R12 stop");
    cyc(1, 'h08, 'h1, 0, 0, "R12 cleared");

    // Mixed random traffic (R2..R12 interactions)
    for (int k = 0; k < 4000; k++) begin
      int pg = $urandom_range(0, 5);
      int sl = $urandom_range(0, 3);
      int a  = (pg << 4) | (sl << 2);
      bit wr = ($urandom_range(0, 5) == 0);
      int wd = (sl == 3) ? $urandom_range(0, 12) : int'($urandom & 'h3F);
      cyc(wr, a, wd, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, "random R12");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule